// File: doc/BRIEF.md
# Serial DAC Register and Trigger Controller

This block is the digital front end of a serially programmed digital-to-analog converter. A host shifts 32-bit frames in over a four-wire SPI-style link made of a serial clock, an active-low frame select, a data input and a data output. All four link signals and the active-low hardware clear pin pass through synchronizers into the system clock domain, and their edges are found there. Each frame has a read/write flag, a register address and a 24-bit data field. A frame takes effect only when exactly 32 serial-clock falling edges arrive before the frame select rises.

The block holds a DAC code register, which is a stub for the converter. It also holds a configuration register, an 8-bit clear preset, a write-only trigger register and an alarm status register. The trigger register gives one-shot commands for software clear, software reset and temperature recalibration. A fixed-latency stub answers the recalibration request. When it completes, it sets the alarm status bit and can pull the active-low alarm pin. A read frame returns the addressed register on the data output during the following frame.

Top module: `dac_serial_ctrl`

## Requirements
- R1: A frame is 32 bits, sent MSB first and sampled on serial-clock falling edges. Bit 31 is the operation (1 = read, 0 = write), bits 30:24 are the address and bits 23:0 are the data. A write to address 01h loads the DAC code from data bits 23:(24-CODE_W).
- R2: A frame whose frame select rises after fewer or more than 32 serial-clock falling edges has no effect.
- R3: After a read frame, the next frame shifts out {1, address, register data} on the data output MSB first. Bit 31 is valid from the fall of the frame select, and each later bit is valid after the next serial-clock falling edge.
- R4: The clear preset at address 03h holds 8 bits in data bits 23:16 and resets to 80h. Its data bits 15:0 read as 0. The configuration register at address 02h holds the readback-mode flag in bit 0 and the alarm-enable flag in bit 1, and resets to 0.
- R5: While the clear pin is low, the DAC code equals the preset placed in the top 8 code bits with zeros below, and writes to the DAC code have no effect.
- R6: A write of trigger bit 5 at address 04h loads the DAC code from the left-justified preset. With readback mode 1 the load happens at the 32nd serial-clock falling edge. With readback mode 0 it happens when the frame select rises.
- R7: A write of trigger bit 6 returns the DAC code, configuration, preset and alarm status to their reset values.
- R8: The trigger register at address 04h always reads back as 0.
- R9: A write of trigger bit 8 starts a recalibration. CAL_LAT cycles later the alarm status bit (bit 0 at address 05h) is set. The alarm pin is low exactly when that bit and the alarm-enable flag are both 1.
- R10: A read of address 05h returns the alarm status and then clears it, which releases the alarm pin.
- R11: After reset the DAC code is 80h placed in the top 8 bits, the alarm pin is high and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sync_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data input |
| clr_n | input | 1 | Active-low hardware clear |
| sdo | output | 1 | Serial data output |
| alarm_n | output | 1 | Active-low alarm pin |
| dac_code | output | CODE_W | DAC code register (stub) |

## Verification
The assertions assume that every serial-clock and frame-select level is held for several system clocks. This lets the two-flop synchronizers see each edge exactly once and in order. They also assume that the frame select never falls in the same system cycle that a serial-clock falling edge is detected. The bench keeps to this by holding every serial-clock phase for six system clocks. It lowers the frame select six clocks before the first rising edge, and it drives the data input before each rising edge so that the data is stable across the falling edge.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;
  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 24;

  localparam logic [ADDR_W-1:0] A_CODE   = 7'h01;
  localparam logic [ADDR_W-1:0] A_CFG    = 7'h02;
  localparam logic [ADDR_W-1:0] A_PRESET = 7'h03;
  localparam logic [ADDR_W-1:0] A_TRIG   = 7'h04;
  localparam logic [ADDR_W-1:0] A_STAT   = 7'h05;

  localparam int TRG_RECAL = 8;
  localparam int TRG_SRST  = 6;
  localparam int TRG_SCLR  = 5;

  localparam logic [7:0] PRESET_RST = 8'h80;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dac_bit_sync.sv
module dac_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/dac_spi_rx.sv
module dac_spi_rx
  import dac_serial_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               sync_s,
  input  logic               sdi_s,
  input  logic [FRAME_W-1:0] tx_word,
  output frame_t             frame,
  output logic               sclk_fall,
  output logic               sync_fall,
  output logic               last_fall,
  output logic               frame_ok,
  output logic               sdo
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic               sclk_q, sync_q;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] rx_sh, tx_sh;
  logic               sync_rise;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign sync_fall = sync_q & ~sync_s;
  assign sync_rise = ~sync_q & sync_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      sync_q    <= 1'b1;
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      last_fall <= 1'b0;
      frame_ok  <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      sync_q    <= sync_s;
      last_fall <= 1'b0;
      frame_ok  <= 1'b0;
      if (sync_fall) begin
        cnt   <= '0;
        tx_sh <= tx_word;
      end else if (sclk_fall && !sync_s) begin
        rx_sh <= {rx_sh[FRAME_W-2:0], sdi_s};
        tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
        if (cnt == CNT_LAST) last_fall <= 1'b1;
      end
      if (sync_rise && cnt == CNT_FULL) frame_ok <= 1'b1;
    end
  end

  assign frame = frame_t'(rx_sh);
  assign sdo   = tx_sh[FRAME_W-1];
endmodule

// File: rtl/dac_cal_stub.sv
module dac_cal_stub #(
  parameter int LAT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(LAT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        cnt  <= CNT_INIT;
      end else if (busy) begin
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_reg_file.sv
module dac_reg_file
  import dac_serial_pkg::*;
#(
  parameter int CODE_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  frame_t             frame,
  input  logic               last_fall,
  input  logic               frame_ok,
  input  logic               clr_act,
  input  logic               cal_done,
  output logic [CODE_W-1:0]  dac_code,
  output logic               rb_mode,
  output logic               alarm_en,
  output logic [7:0]         preset,
  output logic               alm,
  output logic               alarm_n,
  output logic               cal_start,
  output logic               sclr_go,
  output logic               srst_p,
  output logic               code_wr,
  output logic [FRAME_W-1:0] tx_word
);
  localparam int LJ_PAD   = CODE_W - 8;
  localparam int RD_PAD   = DATA_W - CODE_W;
  localparam logic [CODE_W-1:0] CODE_RST = {PRESET_RST, {LJ_PAD{1'b0}}};

  logic              wr, rd, trg_wr, recal;
  logic [CODE_W-1:0] preset_lj;
  logic [DATA_W-1:0] rdata;

  assign wr        = frame_ok & ~frame.rd;
  assign rd        = frame_ok & frame.rd;
  assign trg_wr    = wr && frame.addr == A_TRIG;
  assign srst_p    = trg_wr & frame.data[TRG_SRST];
  assign recal     = trg_wr & frame.data[TRG_RECAL];
  assign code_wr   = wr && frame.addr == A_CODE;
  assign sclr_go   = !frame.rd && frame.addr == A_TRIG && frame.data[TRG_SCLR]
                     && (rb_mode ? last_fall : frame_ok);
  assign preset_lj = {preset, {LJ_PAD{1'b0}}};

  always_comb begin
    rdata = '0;
    case (frame.addr)
      A_CODE:   rdata = {dac_code, {RD_PAD{1'b0}}};
      A_CFG:    rdata = {{(DATA_W-2){1'b0}}, alarm_en, rb_mode};
      A_PRESET: rdata = {preset, 16'h0000};
      A_STAT:   rdata = {{(DATA_W-1){1'b0}}, alm};
      default:  rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || srst_p) dac_code <= CODE_RST;
    else if (clr_act)  dac_code <= preset_lj;
    else if (sclr_go)  dac_code <= preset_lj;
    else if (code_wr)  dac_code <= frame.data[DATA_W-1 -: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst || srst_p) begin
      rb_mode  <= 1'b0;
      alarm_en <= 1'b0;
      preset   <= PRESET_RST;
    end else if (wr) begin
      if (frame.addr == A_CFG) begin
        rb_mode  <= frame.data[0];
        alarm_en <= frame.data[1];
      end
      if (frame.addr == A_PRESET) preset <= frame.data[23:16];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_p)                     alm <= 1'b0;
    else if (cal_done)                     alm <= 1'b1;
    else if (rd && frame.addr == A_STAT)   alm <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word   <= '0;
      cal_start <= 1'b0;
      alarm_n   <= 1'b1;
    end else begin
      cal_start <= recal & ~srst_p;
      alarm_n   <= ~(alm & alarm_en);
      if (srst_p)        tx_word <= '0;
      else if (frame_ok) tx_word <= rd ? {1'b1, frame.addr, rdata} : '0;
    end
  end
endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
  import dac_serial_pkg::*;
#(
  parameter int CODE_W      = 20,
  parameter int CAL_LAT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              sync_n,
  input  logic              sdi,
  input  logic              clr_n,
  output logic              sdo,
  output logic              alarm_n,
  output logic [CODE_W-1:0] dac_code
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1010;

  logic [NSYNC-1:0]   raw_in, syn_out;
  frame_t             frame;
  logic               sclk_fall, sync_fall, last_fall, frame_ok;
  logic [FRAME_W-1:0] tx_word;
  logic               rb_mode, alarm_en, alm, clr_act;
  logic [7:0]         preset;
  logic               cal_start, cal_busy, cal_done;
  logic               sclr_go, srst_p, code_wr;

  assign raw_in  = {clr_n, sdi, sync_n, sclk};
  assign clr_act = ~syn_out[3];

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    dac_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk(clk), .rst(rst), .d(raw_in[g]), .q(syn_out[g])
    );
  end

  dac_spi_rx u_rx (
    .clk(clk), .rst(rst),
    .sclk_s(syn_out[0]), .sync_s(syn_out[1]), .sdi_s(syn_out[2]),
    .tx_word(tx_word), .frame(frame),
    .sclk_fall(sclk_fall), .sync_fall(sync_fall),
    .last_fall(last_fall), .frame_ok(frame_ok), .sdo(sdo)
  );

  dac_reg_file #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .frame(frame), .last_fall(last_fall),
    .frame_ok(frame_ok), .clr_act(clr_act), .cal_done(cal_done),
    .dac_code(dac_code), .rb_mode(rb_mode), .alarm_en(alarm_en),
    .preset(preset), .alm(alm), .alarm_n(alarm_n), .cal_start(cal_start),
    .sclr_go(sclr_go), .srst_p(srst_p), .code_wr(code_wr), .tx_word(tx_word)
  );

  dac_cal_stub #(.LAT(CAL_LAT)) u_cal (
    .clk(clk), .rst(rst), .abort(srst_p), .start(cal_start),
    .busy(cal_busy), .done(cal_done)
  );
endmodule

// File: rtl/dac_serial_ctrl_chk.sv
module dac_serial_ctrl_chk #(
  parameter int CODE_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] dac_code,
  input logic              alarm_n,
  input logic              sdo,
  input logic              clr_act,
  input logic [7:0]        preset,
  input logic              sclr_go,
  input logic              srst_p,
  input logic              code_wr,
  input logic              alm,
  input logic              alarm_en,
  input logic              cal_start,
  input logic              cal_busy,
  input logic              cal_done,
  input logic              sclk_fall,
  input logic              sync_fall
);
  localparam int PAD = CODE_W - 8;

  // R5: a held clear drives the left-justified preset
  a_r5_clr_forces: assert property (@(posedge clk) disable iff (rst)
    (clr_act && $past(clr_act) && !$past(rst) && !$past(srst_p))
      |-> dac_code == {$past(preset), {PAD{1'b0}}});

  // R6: the code moves only for clear, software clear, write or reset
  a_r6_code_source: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(dac_code))
      |-> $past(clr_act || sclr_go || code_wr || srst_p));

  // R8: trigger commands are single-cycle pulses
  a_r8_trig_oneshot: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);

  // R9: a recalibration only starts from idle
  a_r9_start_idle: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> !cal_busy);

  // R9: the status bit only rises on completion
  a_r9_alm_source: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(alm)) |-> $past(cal_done));

  // R9: pin low only when status and enable were both set
  a_r9_alarm_pin: assert property (@(posedge clk) disable iff (rst)
    !alarm_n |-> $past(alm && alarm_en));

  // R3: output bit moves only after a frame start or serial falling edge
  a_r3_sdo_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sclk_fall) && !$past(sync_fall)) |-> $stable(sdo));
endmodule

bind dac_serial_ctrl dac_serial_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .dac_code(dac_code), .alarm_n(alarm_n), .sdo(sdo),
  .clr_act(clr_act), .preset(preset), .sclr_go(sclr_go), .srst_p(srst_p),
  .code_wr(code_wr), .alm(alm), .alarm_en(alarm_en), .cal_start(cal_start),
  .cal_busy(cal_busy), .cal_done(cal_done), .sclk_fall(sclk_fall),
  .sync_fall(sync_fall)
);

// File: tb/test_dac_serial_ctrl.sv
`timescale 1ns/1ps
module test_dac_serial_ctrl;
  localparam int CODE_W  = 20;
  localparam int CAL_LAT = 16;
  localparam int HP      = 6;
  localparam logic [CODE_W-1:0] RST_CODE = {8'h80, 12'h000};

  logic clk = 1'b0, rst = 1'b1;
  logic sclk = 1'b0, sync_n = 1'b1, sdi = 1'b0, clr_n = 1'b1;
  logic sdo, alarm_n;
  logic [CODE_W-1:0] dac_code;
  logic [31:0] got;
  int nchk = 0, nfail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  dac_serial_ctrl #(.CODE_W(CODE_W), .CAL_LAT(CAL_LAT)) i_dac_serial_ctrl (
    .clk(clk), .rst(rst), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
    .clr_n(clr_n), .sdo(sdo), .alarm_n(alarm_n), .dac_code(dac_code)
  );

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift(input logic [31:0] w, input int n);
    sync_n = 1'b0;
    wc(HP);
    for (int i = 0; i < n; i++) begin
      sdi  = (i < 32) ? w[31-i] : 1'b0;
      sclk = 1'b1;
      wc(HP);
      if (i < 32) got[31-i] = sdo;
      sclk = 1'b0;
      wc(HP);
    end
  endtask

  task automatic fin();
    sync_n = 1'b1;
    wc(HP + 4);
  endtask

  task automatic xfer(input logic [31:0] w, input int n);
    shift(w, n);
    fin();
  endtask

  task automatic wr(input logic [6:0] a, input logic [23:0] d);
    xfer({1'b0, a, d}, 32);
  endtask

  task automatic rdreg(input logic [6:0] a, output logic [31:0] v);
    xfer({1'b1, a, 24'h0}, 32);
    xfer(32'h0, 32);
    v = got;
  endtask

  function automatic logic [CODE_W-1:0] lj(input logic [7:0] p);
    return {p, {(CODE_W-8){1'b0}}};
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    logic [CODE_W-1:0] c, held;
    wc(5);
    rst = 1'b0;
    wc(2);
    // R11 reset state
    chk(dac_code == RST_CODE, "R11 code", 32'(dac_code), 32'(RST_CODE));
    chk(alarm_n == 1'b1, "R11 alarm", 32'(alarm_n), 32'd1);
    chk(sdo == 1'b0, "R11 sdo", 32'(sdo), 32'd0);

    // R4 preset and config reset values, R8 trigger readback
    rdreg(7'h03, v);
    chk(v == 32'h8380_0000, "R4 preset reset", v, 32'h8380_0000);
    rdreg(7'h02, v);
    chk(v == 32'h8200_0000, "R4 config reset", v, 32'h8200_0000);
    rdreg(7'h04, v);
    chk(v == 32'h8400_0000, "R8 trigger reads 0", v, 32'h8400_0000);

    // R1 / R3 sweep of codes with readback
    for (int k = 0; k < 8; k++) begin
      c = CODE_W'((k * 32'h2A5C7 + 32'h13) & 32'hFFFFF);
      if (k == 0) c = '0;
      if (k == 7) c = '1;
      wr(7'h01, {c, 4'h0});
      chk(dac_code == c, "R1 code write", 32'(dac_code), 32'(c));
      rdreg(7'h01, v);
      chk(v == {1'b1, 7'h01, c, 4'h0}, "R3 code readback", v, {1'b1, 7'h01, c, 4'h0});
    end

    // R2 short and long frames are ignored
    held = dac_code;
    xfer({1'b0, 7'h01, 24'h123450}, 31);
    chk(dac_code == held, "R2 31 edges", 32'(dac_code), 32'(held));
    xfer({1'b0, 7'h01, 24'h654320}, 33);
    chk(dac_code == held, "R2 33 edges", 32'(dac_code), 32'(held));
    xfer({1'b0, 7'h03, 24'h110000}, 20);
    rdreg(7'h03, v);
    chk(v == 32'h8380_0000, "R2 preset untouched", v, 32'h8380_0000);

    // R4 / R5 preset sweep with hardware clear
    for (int p = 0; p < 256; p += 17) begin
      wr(7'h03, {8'(p), 16'hFFFF});
      rdreg(7'h03, v);
      chk(v == {1'b1, 7'h03, 8'(p), 16'h0}, "R4 preset readback", v,
          {1'b1, 7'h03, 8'(p), 16'h0});
      clr_n = 1'b0;
      wc(8);
      chk(dac_code == lj(8'(p)), "R5 clear value", 32'(dac_code), 32'(lj(8'(p))));
      if (p % 68 == 0) begin
        wr(7'h01, 24'hABCDE0);
        chk(dac_code == lj(8'(p)), "R5 write blocked", 32'(dac_code), 32'(lj(8'(p))));
      end
      clr_n = 1'b1;
      wc(6);
    end

    // R6 software clear, readback mode 0: commit on frame select rise
    wr(7'h03, 24'h5A0000);
    wr(7'h02, 24'h000000);
    wr(7'h01, 24'h123450);
    shift({1'b0, 7'h04, 24'h000020}, 32);
    wc(12);
    chk(dac_code == 20'h12345, "R6 mode0 before rise", 32'(dac_code), 32'h12345);
    fin();
    chk(dac_code == lj(8'h5A), "R6 mode0 after rise", 32'(dac_code), 32'(lj(8'h5A)));
    rdreg(7'h04, v);
    chk(v == 32'h8400_0000, "R8 after clear", v, 32'h8400_0000);

    // R6 software clear, readback mode 1: commit on 32nd falling edge
    wr(7'h02, 24'h000001);
    wr(7'h01, 24'hFEDCB0);
    shift({1'b0, 7'h04, 24'h000020}, 32);
    wc(12);
    chk(dac_code == lj(8'h5A), "R6 mode1 at edge", 32'(dac_code), 32'(lj(8'h5A)));
    fin();
    chk(dac_code == lj(8'h5A), "R6 mode1 after rise", 32'(dac_code), 32'(lj(8'h5A)));

    // R9 / R10 recalibration with alarm pin disabled
    wr(7'h02, 24'h000000);
    wr(7'h04, 24'h000100);
    wc(CAL_LAT + 10);
    chk(alarm_n == 1'b1, "R9 pin masked", 32'(alarm_n), 32'd1);
    rdreg(7'h05, v);
    chk(v == 32'h8500_0001, "R9 status set", v, 32'h8500_0001);
    rdreg(7'h05, v);
    chk(v == 32'h8500_0000, "R10 status cleared", v, 32'h8500_0000);

    // R9 / R10 with alarm pin enabled
    wr(7'h02, 24'h000002);
    wr(7'h04, 24'h000100);
    wc(CAL_LAT + 10);
    chk(alarm_n == 1'b0, "R9 pin low", 32'(alarm_n), 32'd0);
    rdreg(7'h05, v);
    chk(v == 32'h8500_0001, "R10 read value", v, 32'h8500_0001);
    chk(alarm_n == 1'b1, "R10 pin released", 32'(alarm_n), 32'd1);

    // R7 software reset
    wr(7'h02, 24'h000003);
    wr(7'h03, 24'h330000);
    wr(7'h01, 24'h777770);
    wr(7'h04, 24'h000100);
    wc(CAL_LAT + 10);
    wr(7'h04, 24'h000040);
    chk(dac_code == RST_CODE, "R7 code", 32'(dac_code), 32'(RST_CODE));
    chk(alarm_n == 1'b1, "R7 alarm", 32'(alarm_n), 32'd1);
    rdreg(7'h02, v);
    chk(v == 32'h8200_0000, "R7 config", v, 32'h8200_0000);
    rdreg(7'h03, v);
    chk(v == 32'h8380_0000, "R7 preset", v, 32'h8380_0000);
    rdreg(7'h05, v);
    chk(v == 32'h8500_0000, "R7 status", v, 32'h8500_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule